// File: doc/BRIEF.md
# Posted-Write Queue with Read Forwarding

This block lives between a cache and the next memory level. The cache hands it stores and goes on without waiting for memory. The stores sit in a small queue and go out to memory one transaction at a time, oldest first. The same path carries stores from either write policy: every update of a line as it happens, or evicted dirty lines.

When the cache misses on a load, the block first looks through every queued store for the same address. If any match, the data of the most recent matching store comes back to the cache, and memory is not touched. If none match, the load goes to memory ahead of every queued store that has not started yet. A store that is already presented to memory but not yet accepted is allowed to finish first. While a load waits for its memory data, no other memory transaction starts.

The cache-side store port and the memory request port are valid/ready streams. A sender holds valid and its payload steady until the cycle in which ready is also high. The store port drops ready while the queue is full, and the cache must then stall. The load port accepts one miss when ready is high and raises no new ready until the answer has come back. The load answer and the memory read data are single-cycle valid pulses with no back-pressure.

Top module: `wbuf_bypass`

## Requirements
- R1: During and straight after reset, wr_ready and rd_ready are 1 and mem_req_valid and rd_resp_valid are 0.
- R2: A store is taken on any cycle with wr_valid and wr_ready both high. wr_ready is 1 exactly while fewer than DEPTH stores are queued. A full queue holds DEPTH stores.
- R3: Queued stores reach memory in arrival order, as requests with mem_req_write=1 carrying the stored address and data, one per handshake. A presented request keeps valid, write flag, address and data unchanged until mem_req_ready is high.
- R4: A load accepted while one or more queued stores carry its address returns, on rd_resp_valid in the next cycle, the data of the youngest such store, and issues no memory request.
- R5: A load with no queued match is presented to memory (mem_req_write=0, its address) in the cycle after acceptance, ahead of queued stores. The only exception is a store already presented and not yet taken: that store completes first, and the load follows in the next cycle.
- R6: While a load waits for memory data, mem_req_valid stays 0. The cycle after mem_resp_valid, rd_resp_valid pulses with mem_resp_data.
- R7: rd_ready is 1 only while no load is outstanding. A load that goes to memory drops rd_ready from the next cycle until its answer is delivered.
- R8: A load and a store accepted in the same cycle are ordered load first: the load's search does not see that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store offered by the cache |
| wr_ready | output | 1 | Queue can take a store |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Load miss offered by the cache |
| rd_ready | output | 1 | No load outstanding; a new one is taken |
| rd_addr | input | AW | Load address |
| rd_resp_valid | output | 1 | Load answer pulse |
| rd_resp_data | output | DW | Load answer data |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Store data for a write request |
| mem_resp_valid | input | 1 | Memory read data pulse |
| mem_resp_data | input | DW | Memory read data |

## Verification
A wrong queue pointer or occupancy count shows at the ports within one or two cycles. wr_ready goes wrong at the fill limit, a store is drained out of order, or a forwarded load returns stale data in the cycle after it is accepted. A wrong hold flag shows as a load jumping in front of a store that was already presented to memory, or as a store left stranded. A stuck load state shows as rd_ready staying low, or as memory traffic starting while a load is still waiting. The reference model compares every output on every cycle, so each of these is caught in the cycle where it first appears.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
// Circular store queue with an age-ordered address search.
module wbuf_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          look_hit,
  output logic [DW-1:0] look_data
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [DEPTH-1:0] age_match;
  logic [DW-1:0]    age_data [DEPTH];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (push) tail <= ptr_inc(tail);
      if (pop)  head <= ptr_inc(head);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail] <= push_addr;
      slot_data[tail] <= push_data;
    end
  end

  // Entry k of the age view is the k-th oldest queued store.
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PW:0]   sum;
    logic [PW-1:0] idx;
    assign sum  = {1'b0, head} + (PW+1)'(k);
    assign idx  = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : sum[PW-1:0];
    assign age_match[k] = (CW'(k) < level) && (slot_addr[idx] == look_addr);
    assign age_data[k]  = slot_data[idx];
  end

  // Youngest match wins: later ages overwrite earlier ones.
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (age_match[k]) begin
        look_hit  = 1'b1;
        look_data = age_data[k];
      end
    end
  end

  assign head_addr = slot_addr[head];
  assign head_data = slot_data[head];
  assign full      = (level == CW'(DEPTH));
  assign empty     = (level == '0);
endmodule

// File: rtl/wbuf_arb.sv
// Memory-side arbiter: load first, except a store already presented.
module wbuf_arb #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_pending,
  input  logic          rd_idle,
  input  logic [AW-1:0] rd_addr_q,
  input  logic          buf_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_req_ready,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  output logic          rd_grant,
  output logic          pop
);
  logic wr_hold;
  logic rd_sel, wr_sel;

  assign rd_sel = rd_pending && !wr_hold;
  assign wr_sel = !buf_empty && (wr_hold || rd_idle);

  always_ff @(posedge clk) begin
    if (!rst_n) wr_hold <= 1'b0;
    else        wr_hold <= wr_sel && !mem_req_ready;
  end

  assign mem_req_valid = rd_sel || wr_sel;
  assign mem_req_write = !rd_sel;
  assign mem_req_addr  = rd_sel ? rd_addr_q : head_addr;
  assign mem_req_data  = rd_sel ? '0 : head_data;
  assign rd_grant      = rd_sel && mem_req_ready;
  assign pop           = wr_sel && mem_req_ready;
endmodule

// File: rtl/wbuf_rdctl.sv
// Load-miss sequencer: forward on match, else fetch from memory.
module wbuf_rdctl
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          look_hit,
  input  logic [DW-1:0] look_data,
  input  logic          rd_grant,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data,
  output logic          rd_ready,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic [AW-1:0] rd_addr_q,
  output rd_state_e     st
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= RD_IDLE;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
      rd_addr_q     <= '0;
    end else begin
      rd_resp_valid <= 1'b0;
      unique case (st)
        RD_IDLE: if (rd_valid) begin
          if (look_hit) begin
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= look_data;
          end else begin
            st        <= RD_ISSUE;
            rd_addr_q <= rd_addr;
          end
        end
        RD_ISSUE: if (rd_grant) st <= RD_WAIT;
        RD_WAIT: if (mem_resp_valid) begin
          rd_resp_valid <= 1'b1;
          rd_resp_data  <= mem_resp_data;
          st            <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign rd_ready = (st == RD_IDLE);
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_resp_valid,
  input  logic [DW-1:0] mem_resp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          buf_full, buf_empty, buf_hit, push, pop, rd_grant;
  logic [CW-1:0] buf_level;
  logic [AW-1:0] head_addr, rd_addr_q;
  logic [DW-1:0] head_data, buf_hit_data;
  rd_state_e     rd_st;

  assign wr_ready = !buf_full;
  assign push     = wr_valid && !buf_full;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(pop), .look_addr(rd_addr),
    .head_addr(head_addr), .head_data(head_data),
    .level(buf_level), .full(buf_full), .empty(buf_empty),
    .look_hit(buf_hit), .look_data(buf_hit_data)
  );

  wbuf_rdctl #(.AW(AW), .DW(DW)) u_rdctl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .look_hit(buf_hit), .look_data(buf_hit_data),
    .rd_grant(rd_grant),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .rd_addr_q(rd_addr_q), .st(rd_st)
  );

  wbuf_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rd_pending(rd_st == RD_ISSUE), .rd_idle(rd_st == RD_IDLE),
    .rd_addr_q(rd_addr_q), .buf_empty(buf_empty),
    .head_addr(head_addr), .head_data(head_data),
    .mem_req_ready(mem_req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .rd_grant(rd_grant), .pop(pop)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk
  import wbuf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_resp_valid,
  input logic [DW-1:0] rd_resp_data,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_data,
  input logic [$clog2(DEPTH+1)-1:0] buf_level,
  input logic          buf_hit,
  input logic [DW-1:0] buf_hit_data,
  input rd_state_e     rd_st
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r2_level_limit: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= CW'(DEPTH));

  a_r2_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> buf_level == CW'(DEPTH));

  a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_data));

  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && buf_hit |=> rd_resp_valid && rd_resp_data == $past(buf_hit_data));

  a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !buf_hit |=> mem_req_valid
      && (!mem_req_write || $past(mem_req_valid && mem_req_write && !mem_req_ready)));

  a_r6_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st == RD_WAIT |-> !mem_req_valid);

  a_r7_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !buf_hit |=> !rd_ready);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
  .buf_level(buf_level), .buf_hit(buf_hit), .buf_hit_data(buf_hit_data), .rd_st(rd_st)
);

// File: tb/wbuf_bypass_bench.sv
module wbuf_bypass_bench;
  localparam int AW = 16, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_valid = 1'b0, mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, mem_resp_data = '0;
  logic wr_ready, rd_ready, rd_resp_valid, mem_req_valid, mem_req_write;
  logic [DW-1:0] rd_resp_data, mem_req_data;
  logic [AW-1:0] mem_req_addr;

  always #5 clk = ~clk;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_wbuf_bypass (.*);

  int errors = 0, checks = 0, rdy_mode = 0;
  bit chk_en = 0, done = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t q[$];
  int   mst = 0;
  bit   hold = 0, rv_m = 0, last_hit = 0;
  logic [AW-1:0] rqa = '0;
  logic [DW-1:0] rd_m = '0;

  function automatic bit m_rsel(); return mst == 1 && !hold; endfunction
  function automatic bit m_wsel(); return q.size() > 0 && (hold || mst == 0); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mst = 0; hold = 0; rv_m = 0; last_hit = 0;
    end else begin
      bit rs, ws, hit;
      int nmst, qs;
      logic [DW-1:0] hd;
      rs = m_rsel(); ws = m_wsel(); nmst = mst; qs = q.size();
      rv_m = 0;
      if (mst == 0 && rd_valid) begin
        hit = 0; hd = '0;
        foreach (q[i]) if (q[i].a == rd_addr) begin hit = 1; hd = q[i].d; end
        if (hit) begin rv_m = 1; rd_m = hd; last_hit = 1; end
        else begin nmst = 1; rqa = rd_addr; end
      end
      if (mst == 1 && rs && mem_req_ready) nmst = 2;
      if (mst == 2 && mem_resp_valid) begin
        rv_m = 1; rd_m = mem_resp_data; last_hit = 0; nmst = 0;
      end
      hold = ws && !mem_req_ready;
      if (ws && mem_req_ready) void'(q.pop_front());
      if (wr_valid && qs < DEPTH) q.push_back('{wr_addr, wr_data});
      mst = nmst;
    end
  end

  always @(negedge clk) if (chk_en) begin
    bit rs, ws;
    rs = m_rsel(); ws = m_wsel();
    chk(wr_ready == (q.size() < DEPTH), "R2 wr_ready", 64'(wr_ready), 64'(q.size() < DEPTH));
    chk(rd_ready == (mst == 0), "R7 rd_ready", 64'(rd_ready), 64'(mst == 0));
    chk(mem_req_valid == (rs || ws), "R5 mem_req_valid", 64'(mem_req_valid), 64'(rs || ws));
    if (mem_req_valid && (rs || ws)) begin
      chk(mem_req_write == !rs, "R5 mem_req_write", 64'(mem_req_write), 64'(!rs));
      chk(mem_req_addr == (rs ? rqa : q[0].a), "R3 mem_req_addr",
          64'(mem_req_addr), 64'(rs ? rqa : q[0].a));
      if (!rs) chk(mem_req_data == q[0].d, "R3 mem_req_data", 64'(mem_req_data), 64'(q[0].d));
    end
    chk(rd_resp_valid == rv_m, last_hit ? "R4 rd_resp_valid" : "R6 rd_resp_valid",
        64'(rd_resp_valid), 64'(rv_m));
    if (rv_m) chk(rd_resp_data == rd_m, last_hit ? "R4 rd_resp_data" : "R6 rd_resp_data",
                  64'(rd_resp_data), 64'(rd_m));
  end

  // Bench memory
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] exp_mem [logic [AW-1:0]];
  function automatic logic [DW-1:0] rdmem(logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : (DW'(a) * 3 + 7);
  endfunction

  initial begin
    int lat = 0;
    logic [AW-1:0] ra = '0;
    forever begin
      bit hs, hw;
      logic [AW-1:0] ha;
      logic [DW-1:0] hd;
      @(negedge clk);
      hs = mem_req_valid && mem_req_ready; hw = mem_req_write;
      ha = mem_req_addr; hd = mem_req_data;
      @(posedge clk); #1;
      mem_resp_valid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin mem_resp_valid = 1'b1; mem_resp_data = rdmem(ra); end
      end
      if (hs && rst_n) begin
        if (hw) mem[ha] = hd;
        else begin lat = 2; ra = ha; end
      end
      mem_req_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ($urandom % 3 != 0) : 1'b0;
    end
  end

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    forever begin @(negedge clk); if (wr_ready) break; end
    @(posedge clk); #1;
    wr_valid = 0; exp_mem[a] = d;
  endtask

  task automatic do_read(logic [AW-1:0] a);
    rd_valid = 1; rd_addr = a;
    forever begin @(negedge clk); if (rd_ready) break; end
    @(posedge clk); #1;
    rd_valid = 0;
  endtask

  task automatic wait_resp(output logic [DW-1:0] d);
    forever begin @(negedge clk); if (rd_resp_valid) break; end
    d = rd_resp_data;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_ready && rd_ready && !mem_req_valid && !rd_resp_valid, "R1 in reset",
        {wr_ready, rd_ready, mem_req_valid, rd_resp_valid}, 4'b1100);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(wr_ready && rd_ready && !mem_req_valid && !rd_resp_valid, "R1 after reset",
        {wr_ready, rd_ready, mem_req_valid, rd_resp_valid}, 4'b1100);
    chk_en = 1;
    @(posedge clk); #1;

    // Fill with memory stalled; same address twice
    rdy_mode = 0;
    do_write(16'h0010, 32'h1111_0001);
    do_write(16'h0020, 32'h2222_0002);
    do_write(16'h0010, 32'h1111_0003);
    do_write(16'h0030, 32'h3333_0004);
    @(negedge clk);
    chk(!wr_ready, "R2 full stall", 64'(wr_ready), 0);
    @(posedge clk); #1;

    // Forward youngest match
    do_read(16'h0010);
    wait_resp(got);
    chk(got == 32'h1111_0003, "R4 youngest", 64'(got), 64'h1111_0003);

    // Miss behind a presented store, then memory opens
    do_read(16'h0040);
    idle(3);
    rdy_mode = 1;
    wait_resp(got);
    chk(got == rdmem(16'h0040), "R5 miss data", 64'(got), 64'(rdmem(16'h0040)));
    idle(20);

    // Same-cycle load and store to one address
    wr_valid = 1; wr_addr = 16'h0777; wr_data = 32'hDEAD_BEEF;
    rd_valid = 1; rd_addr = 16'h0777;
    @(posedge clk); #1;
    wr_valid = 0; rd_valid = 0; exp_mem[16'h0777] = 32'hDEAD_BEEF;
    wait_resp(got);
    chk(got == (DW'(16'h0777) * 3 + 7), "R8 ordering", 64'(got), 64'(DW'(16'h0777) * 3 + 7));
    idle(10);

    // Mixed traffic with irregular memory ready
    rdy_mode = 2;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 4;
      if (op < 2) do_write(16'h0100 + AW'($urandom % 8), $urandom);
      else if (op == 2) do_read(16'h0100 + AW'($urandom % 8));
      else idle(1);
    end
    rdy_mode = 1;
    idle(40);
    foreach (exp_mem[a])
      chk(mem.exists(a) && mem[a] == exp_mem[a], "R3 drained contents",
          64'(rdmem(a)), 64'(exp_mem[a]));
    finish_run();
  end
endmodule